// File: doc/BRIEF.md
# PWM Sweep Response Characteriser

This block measures the response curve of a plant driven by a PWM output. While it waits in its idle state it watches a byte-wide receive stream. When the start byte arrives it begins a sweep. The sweep sets the PWM duty code to 0 and raises it by one code at a time until it reaches the top code. After each duty change the block first lets the plant settle for a set number of whole PWM periods. It then takes a power-of-two number of ADC samples through a valid/ready handshake, averages them, and writes the average into an on-chip table at the address equal to the duty code. The duty code itself is not stored.

When the entry for the top code has been written, the controller goes back to idle and gives a single-cycle done pulse. A separate read port lets a later stage dump the table at any time, with registered read data.

The controller has two states. `ST_IDLE` waits for the start byte, and the transition `start` leads to `ST_SCAN`. `ST_SCAN` covers settling, sampling and writing, and the transition `finish`, taken on the write of the last code, leads back to `ST_IDLE`. Default sizes are a 10-bit duty code (1024-clock period, about 48.8 kHz from 50 MHz), 10-bit samples and 8 samples per step.

Top module: `pwm_sweep_char`

## Requirements
- R1: Reset state: `busy`, `done`, `pwm_out` and `smp_ready` are all 0, and `duty` is 0.
- R2: In idle, a receive beat (`rx_valid`=1) carrying `START_CODE` (default 8'h53) makes `busy` 1 from the next clock with `duty`=0. Any other byte value leaves the block idle.
- R3: Receive beats that arrive while `busy` is 1 are ignored, and the sweep continues unchanged.
- R4: A free-running counter of period 2^DUTY_W clocks runs from reset. In each clock, `pwm_out` is set to 1 exactly when the counter value of the previous clock was below `duty`. In idle `duty` is 0, so `pwm_out` stays low.
- R5: When a sweep starts and at each duty change, a settle count is loaded with `SETTLE_PERIODS`. The count drops by one in each clock where the counter holds its maximum value. `smp_ready` is 0 until the count reaches zero.
- R6: Each step accepts 2^LOG2_SAMPLES samples. The stored value is their sum shifted right by LOG2_SAMPLES, which gives the floor of the mean.
- R7: The table address written is the current `duty`. `duty` starts at 0 and moves up by exactly 1 after each step's write.
- R8: The write for the top code ends the sweep. In the next clock `busy` is 0, `duty` is 0, and `done` is 1 for exactly that one clock.
- R9: `rd_data` shows the table entry at `rd_addr` one clock after the address is presented.
- R10: `smp_ready` is 1 only while busy and settled. A sample is taken only in a clock where both `smp_valid` and `smp_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_byte | input | 8 | Received byte |
| smp_valid | input | 1 | ADC sample valid |
| smp_data | input | SMP_W | ADC sample value |
| smp_ready | output | 1 | Block accepts a sample this clock |
| pwm_out | output | 1 | PWM drive output |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-clock pulse at the end of a sweep |
| duty | output | DUTY_W | Current duty code |
| rd_addr | input | DUTY_W | Table read address |
| rd_data | output | SMP_W | Table read data, one clock latency |

## Verification
The bench runs a behavioural model alongside the block and compares `busy`, `done`, `duty`, `pwm_out` and `smp_ready` on every clock. Because of this, a wrong settle count, sample count or state shows up at the ports within one clock as a mismatch on `smp_ready`, `duty` or `busy`. A wrong average or a wrong write address does not show up during the sweep. It is caught when the whole table is read back through the read port after each sweep, with each entry compared against the model's expected table.

// File: rtl/swp_pkg.sv
package swp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } swp_state_t;
endpackage

// File: rtl/swp_pwm.sv
module swp_pwm #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_out,
    output logic              period_end
);
    logic [DUTY_W-1:0] cnt_q;

    assign period_end = (cnt_q == {DUTY_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pwm_out <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            pwm_out <= (cnt_q < duty);
        end
    end
endmodule

// File: rtl/swp_accum.sv
module swp_accum #(
    parameter int IN_W  = 10,
    parameter int ACC_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [IN_W-1:0]  din,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (add) acc <= acc + ACC_W'(din);
    end
endmodule

// File: rtl/swp_ram.sv
module swp_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pwm_sweep_char.sv
module pwm_sweep_char
    import swp_pkg::*;
#(
    parameter int         DUTY_W         = 10,
    parameter int         SMP_W          = 10,
    parameter int         LOG2_SAMPLES   = 3,
    parameter int         SETTLE_PERIODS = 4,
    parameter logic [7:0] START_CODE     = 8'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              smp_ready,
    output logic              pwm_out,
    output logic              busy,
    output logic              done,
    output logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] rd_addr,
    output logic [SMP_W-1:0]  rd_data
);
    localparam int ACC_W = SMP_W + LOG2_SAMPLES;
    localparam int SET_W = $clog2(SETTLE_PERIODS + 1);
    localparam logic [DUTY_W-1:0]       DUTY_TOP = {DUTY_W{1'b1}};
    localparam logic [LOG2_SAMPLES-1:0] SMP_LAST = {LOG2_SAMPLES{1'b1}};

    swp_state_t              state_q, state_d;
    logic [SET_W-1:0]        settle_q;
    logic [LOG2_SAMPLES-1:0] smp_cnt_q;
    logic [DUTY_W-1:0]       duty_q;
    logic                    done_q;
    logic                    period_end;
    logic                    start_hit, fire, step_last, sweep_end;
    logic [ACC_W-1:0]        acc, sum_full;
    logic [SMP_W-1:0]        avg;

    assign start_hit = rx_valid && (rx_byte == START_CODE);
    assign fire      = smp_ready && smp_valid;
    assign step_last = fire && (smp_cnt_q == SMP_LAST);
    assign sweep_end = step_last && (duty_q == DUTY_TOP);
    assign sum_full  = acc + ACC_W'(smp_data);
    assign avg       = sum_full[ACC_W-1:LOG2_SAMPLES];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start (idle -> scan), finish (scan -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_hit) state_d = ST_SCAN;
            ST_SCAN: if (sweep_end) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        smp_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SCAN: begin
                busy      = 1'b1;
                smp_ready = (settle_q == '0);
            end
        endcase
    end

    assign duty = duty_q;
    assign done = done_q;

    // sweep datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q  <= '0;
            smp_cnt_q <= '0;
            duty_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= sweep_end;
            if (state_q == ST_IDLE) begin
                if (start_hit) begin
                    duty_q    <= '0;
                    settle_q  <= SET_W'(SETTLE_PERIODS);
                    smp_cnt_q <= '0;
                end
            end else begin
                if (period_end && settle_q != '0)
                    settle_q <= settle_q - 1'b1;
                if (fire) begin
                    smp_cnt_q <= smp_cnt_q + 1'b1;
                    if (step_last) begin
                        if (duty_q == DUTY_TOP) begin
                            duty_q <= '0;
                        end else begin
                            duty_q   <= duty_q + 1'b1;
                            settle_q <= SET_W'(SETTLE_PERIODS);
                        end
                    end
                end
            end
        end
    end

    swp_pwm #(.DUTY_W(DUTY_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .duty(duty_q),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    swp_accum #(.IN_W(SMP_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .clr((state_q == ST_IDLE && start_hit) || step_last),
        .add(fire && !step_last),
        .din(smp_data), .acc(acc)
    );

    swp_ram #(.ADDR_W(DUTY_W), .DATA_W(SMP_W)) u_ram (
        .clk(clk), .we(step_last), .waddr(duty_q), .wdata(avg),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/swp_chk.sv
module swp_chk #(
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              pwm_out,
    input logic              smp_ready,
    input logic [DUTY_W-1:0] duty
);
    AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> busy); // R10
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && duty == '0); // R8
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_SWEEP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> duty == '0); // R2
    AST_DUTY_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && duty != $past(duty)) |-> duty == $past(duty) + 1'b1); // R7
    AST_PWM_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !pwm_out); // R4
endmodule

bind pwm_sweep_char swp_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .pwm_out(pwm_out), .smp_ready(smp_ready), .duty(duty)
);

// File: tb/sim_pwm_sweep_char.sv
module sim_pwm_sweep_char;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 4;
    localparam int SW = 10;
    localparam int L2 = 3;
    localparam int SET = 2;
    localparam int NS = 1 << L2;
    localparam int PER = 1 << DW;
    localparam logic [7:0] START = 8'h53;

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, smp_valid = 0;
    logic [7:0] rx_byte = 0;
    logic [SW-1:0] smp_data = 0;
    logic [DW-1:0] rd_addr = 0;
    logic smp_ready, pwm_out, busy, done;
    logic [DW-1:0] duty;
    logic [SW-1:0] rd_data;

    int total = 0, bad = 0;
    bit compare_on = 0;

    // model state
    int m_cnt, m_duty, m_settle, m_sum, m_k;
    bit m_busy, m_pwm, m_done;
    int exp_mem [PER];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_sweep_char #(.DUTY_W(DW), .SMP_W(SW), .LOG2_SAMPLES(L2),
                     .SETTLE_PERIODS(SET), .START_CODE(START)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .pwm_out(pwm_out), .busy(busy), .done(done), .duty(duty),
        .rd_addr(rd_addr), .rd_data(rd_data));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, stepped on each clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_duty = 0; m_settle = 0; m_sum = 0; m_k = 0;
            m_busy = 0; m_pwm = 0; m_done = 0;
        end else begin
            bit rdy, nxt_pwm, nxt_done, wrap;
            rdy = m_busy && (m_settle == 0);
            wrap = (m_cnt == PER - 1);
            nxt_pwm = (m_cnt < m_duty);
            nxt_done = 0;
            if (!m_busy) begin
                if (rx_valid && rx_byte == START) begin
                    m_busy = 1; m_duty = 0; m_settle = SET; m_sum = 0; m_k = 0;
                end
            end else begin
                if (wrap && m_settle != 0) m_settle--;
                if (rdy && smp_valid) begin
                    m_sum += int'(smp_data);
                    m_k++;
                    if (m_k == NS) begin
                        exp_mem[m_duty] = m_sum / NS;
                        m_sum = 0; m_k = 0;
                        if (m_duty == PER - 1) begin
                            m_busy = 0; m_duty = 0; nxt_done = 1;
                        end else begin
                            m_duty++; m_settle = SET;
                        end
                    end
                end
            end
            m_cnt = (m_cnt + 1) % PER;
            m_pwm = nxt_pwm;
            m_done = nxt_done;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            chk(busy == m_busy, "R2/R3/R8 busy", busy, m_busy);
            chk(done == m_done, "R8 done", done, m_done);
            chk(int'(duty) == m_duty, "R7 duty", duty, m_duty);
            chk(pwm_out == m_pwm, "R4 pwm_out", pwm_out, m_pwm);
            chk(smp_ready == (m_busy && m_settle == 0), "R5/R10 smp_ready",
                smp_ready, (m_busy && m_settle == 0));
        end
    end

    // random sample stream
    always @(negedge clk) begin
        smp_valid <= ($urandom_range(0, 3) != 0);
        smp_data  <= SW'($urandom_range(0, (1 << SW) - 1));
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_byte = b;
        @(negedge clk);
        rx_valid = 0; rx_byte = 0;
    endtask

    task automatic dump_table(input string tag);
        for (int a = 0; a < PER; a++) begin
            @(negedge clk);
            rd_addr = DW'(a);
            @(negedge clk);
            chk(int'(rd_data) == exp_mem[a], {"R6/R9 table ", tag}, rd_data, exp_mem[a]);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
        chk(smp_ready == 0, "R1 smp_ready", smp_ready, 0);
        chk(duty == 0, "R1 duty", duty, 0);
        rst_n = 1;
        compare_on = 1;
        repeat (4) @(negedge clk);

        // R2: wrong byte leaves idle
        send_byte(8'h41);
        chk(busy == 0, "R2 wrong byte ignored", busy, 0);
        repeat (PER) @(negedge clk);
        chk(pwm_out == 0, "R4 idle pwm low", pwm_out, 0);

        // R2: start byte
        send_byte(START);
        chk(busy == 1, "R2 start", busy, 1);
        chk(duty == 0, "R2 start duty", duty, 0);

        // R3: start bytes mid-sweep ignored
        repeat (200) @(negedge clk);
        begin
            int d0;
            d0 = int'(duty);
            send_byte(START);
            chk(busy == 1, "R3 start during sweep", busy, 1);
            chk(int'(duty) >= d0, "R3 duty not restarted", duty, d0);
        end
        wait_idle();
        dump_table("sweep1");

        // second sweep with different data
        send_byte(START);
        wait_idle();
        chk(busy == 0, "R8 back to idle", busy, 0);
        dump_table("sweep2");

        compare_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule